// File: doc/BRIEF.md
# Dual-Link Byte-Interleaved Backplane Multiplexer

This block takes the received streams of two framed links and merges them onto one serial backplane line running at four times the rate of a single link. Each link arrives already converted to a 32-timeslot, 2.048 Mb/s frame. Its bytes are written into the block one timeslot at a time, each with its timeslot index and a 4-bit signaling code. An external backplane clock and frame pulse time the output. Over a 125 µs frame the block sends 128 byte positions at 8.192 Mb/s. Within each group of four positions, link 0 comes first, then link 1, and two idle bytes fill the rest. A second serial line carries the signaling for each channel in the same bit times as its data byte.

Each link has a one-byte holding register. This register lets the link side write at its own pace, as long as each byte arrives before the backplane needs it. A byte that is missing or carries the wrong timeslot index is replaced by all-ones idle.

The block checks its mapping-select input. The code that means "no rate mapping" cannot be used in multiplexed operation. While that code is present, the block flags a configuration error and holds both serial lines idle.

The sequencer state machine has five states:
- HUNT: idle, waiting for a frame pulse.
- LINK0: shifting a link 0 byte.
- LINK1: shifting a link 1 byte.
- FILL: shifting an idle position.
- CFGERR: illegal mapping selected.

Its transitions are:
- Any state goes to CFGERR on the illegal code.
- CFGERR goes to HUNT when a legal code returns.
- Any state goes to LINK0 on a frame pulse with a legal code.
- At the last bit of a byte, LINK0, LINK1 or FILL moves to the state that matches the next position's lane: lane 0 gives LINK0, lane 1 gives LINK1, lanes 2 and 3 give FILL.
- Otherwise the state holds.

Top module: `bp_byte_mux`

## Requirements
- R1: When `fp` is high with a legal `map_sel` at a rising edge, the MSB of byte position 0 appears on `sdata` after that edge. Each later edge presents the next lower bit, and every byte is 8 bits long, MSB first.
- R2: Byte position 4k carries link 0 timeslot k, and position 4k+1 carries link 1 timeslot k, for k in 0..31.
- R3: Byte positions 4k+2 and 4k+3 are all ones on both `sdata` and `ssig`.
- R4: During a link byte, `ssig` carries the byte {4'b1111, sig[3:0]} for that link and timeslot, bit-aligned with the data byte, so that its first four bits are ones.
- R5: A byte written with index k on an edge strictly before the edge that loads the link's position for slot k is sent in that position.
- R6: Each load of a link position empties that link's holding register. If the register was empty, or held a different timeslot index, the position is sent as all ones on both lines.
- R7: Without a new frame pulse, the sequence wraps from position 127 back to position 0 and continues.
- R8: A frame pulse in the middle of a frame restarts the sequence at position 0, bit 0.
- R9: While `map_sel` is 2'b00, `cfg_err` is 1 after the next edge. From that edge on, `sdata` and `ssig` are 1, the holding registers are emptied and link writes are ignored. For any other code, `cfg_err` is 0 after the next edge.
- R10: Out of reset, and after leaving the error condition, both serial lines stay 1 until a frame pulse arrives.
- R11: During reset, `sdata` and `ssig` are 1, `cfg_err` is 0 and both holding registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bp_clk | input | 1 | Backplane bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fp | input | 1 | Frame pulse, marks bit 0 of byte position 0 |
| map_sel | input | 2 | Rate-mapping select; 2'b00 is illegal here |
| l0_wr | input | 1 | Link 0 byte write strobe |
| l0_ts | input | 5 | Link 0 timeslot index of the written byte |
| l0_data | input | 8 | Link 0 data byte |
| l0_sig | input | 4 | Link 0 signaling code |
| l1_wr | input | 1 | Link 1 byte write strobe |
| l1_ts | input | 5 | Link 1 timeslot index of the written byte |
| l1_data | input | 8 | Link 1 data byte |
| l1_sig | input | 4 | Link 1 signaling code |
| sdata | output | 1 | Multiplexed serial data |
| ssig | output | 1 | Multiplexed serial signaling |
| cfg_err | output | 1 | Illegal mapping selected |

## Verification
The assertions assume two things about the environment. First, the frame pulse and all link writes are synchronous to the backplane clock. Second, a link writes at most one byte per edge, so a consume followed by a quiet cycle leaves its holding register empty.

The stimulus is keyed to a phase counter that follows the bench's own frame pulses. Each link byte is written a few bit times before the position that reads it. The bench deliberately departs from this on a few cases: one skipped write, one write with a wrong index, one frame with no pulse, one mid-frame pulse, and one window with the illegal mapping code, during which writes continue.

// File: rtl/bp_mux_pkg.sv
package bp_mux_pkg;

    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_LINK0  = 3'd1,
        ST_LINK1  = 3'd2,
        ST_FILL   = 3'd3,
        ST_CFGERR = 3'd4
    } seq_state_t;

    localparam logic [1:0] MAP_RAW = 2'b00;

    localparam int LINKS        = 2;
    localparam int POS_PER_SLOT = 4;

endpackage

// File: rtl/link_hold.sv
module link_hold #(
    parameter int TS_W   = 5,
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SIG_W-1:0]  wr_sig,
    input  logic              rd,
    output logic              valid,
    output logic [TS_W-1:0]   ts,
    output logic [BYTE_W-1:0] data,
    output logic [SIG_W-1:0]  sig
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ts    <= '0;
            data  <= '1;
            sig   <= '1;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (wr) begin
            valid <= 1'b1;
            ts    <= wr_ts;
            data  <= wr_data;
            sig   <= wr_sig;
        end else if (rd) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import bp_mux_pkg::*;
#(
    parameter int FRAME_POS = 128,
    parameter int BYTE_W    = 8,
    localparam int POS_W    = $clog2(FRAME_POS),
    localparam int BIT_W    = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp,
    input  logic             legal,
    output logic             load,
    output logic [POS_W-1:0] load_pos,
    output logic             force_idle,
    output seq_state_t       state,
    output logic [BIT_W-1:0] bit_cnt
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_POS - 1);

    seq_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic [BIT_W-1:0] bit_q;
    logic             running;

    always_comb begin
        running = (state_q == ST_LINK0) || (state_q == ST_LINK1) ||
                  (state_q == ST_FILL);
    end

    // output process
    always_comb begin
        load       = 1'b0;
        load_pos   = '0;
        force_idle = 1'b1;
        unique case (state_q)
            ST_HUNT, ST_CFGERR: begin
                load       = legal && fp;
                load_pos   = '0;
                force_idle = !load;
            end
            ST_LINK0, ST_LINK1, ST_FILL: begin
                load = legal && (fp || (bit_q == LAST_BIT));
                if (fp || (pos_q == LAST_POS)) begin
                    load_pos = '0;
                end else begin
                    load_pos = pos_q + POS_W'(1);
                end
                force_idle = !legal;
            end
            default: begin
                load       = 1'b0;
                force_idle = 1'b1;
            end
        endcase
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        if (!legal) begin
            state_d = ST_CFGERR;
        end else if (load) begin
            unique case (load_pos[1:0])
                2'd0:    state_d = ST_LINK0;
                2'd1:    state_d = ST_LINK1;
                default: state_d = ST_FILL;
            endcase
        end else begin
            unique case (state_q)
                ST_HUNT:   state_d = ST_HUNT;
                ST_CFGERR: state_d = ST_HUNT;
                ST_LINK0:  state_d = ST_LINK0;
                ST_LINK1:  state_d = ST_LINK1;
                ST_FILL:   state_d = ST_FILL;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            bit_q <= '0;
        end else if (load) begin
            pos_q <= load_pos;
            bit_q <= '0;
        end else if (running && legal) begin
            bit_q <= bit_q + BIT_W'(1);
        end
    end

    assign state   = state_q;
    assign bit_cnt = bit_q;

endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              force_idle,
    input  logic [BYTE_W-1:0] d_in,
    input  logic [BYTE_W-1:0] s_in,
    output logic              sdata,
    output logic              ssig
);

    logic [BYTE_W-1:0] dsh_q, ssh_q;

    always_ff @(posedge clk) begin
        if (!rst_n || force_idle) begin
            dsh_q <= '1;
            ssh_q <= '1;
        end else if (load) begin
            dsh_q <= d_in;
            ssh_q <= s_in;
        end else begin
            dsh_q <= {dsh_q[BYTE_W-2:0], 1'b1};
            ssh_q <= {ssh_q[BYTE_W-2:0], 1'b1};
        end
    end

    assign sdata = dsh_q[BYTE_W-1];
    assign ssig  = ssh_q[BYTE_W-1];

endmodule

// File: rtl/bp_byte_mux.sv
module bp_byte_mux
    import bp_mux_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4,
    localparam int TS_W      = $clog2(SLOTS),
    localparam int FRAME_POS = SLOTS * POS_PER_SLOT,
    localparam int POS_W     = $clog2(FRAME_POS),
    localparam int BIT_W     = $clog2(BYTE_W)
) (
    input  logic              bp_clk,
    input  logic              rst_n,
    input  logic              fp,
    input  logic [1:0]        map_sel,
    input  logic              l0_wr,
    input  logic [TS_W-1:0]   l0_ts,
    input  logic [BYTE_W-1:0] l0_data,
    input  logic [SIG_W-1:0]  l0_sig,
    input  logic              l1_wr,
    input  logic [TS_W-1:0]   l1_ts,
    input  logic [BYTE_W-1:0] l1_data,
    input  logic [SIG_W-1:0]  l1_sig,
    output logic              sdata,
    output logic              ssig,
    output logic              cfg_err
);

    logic                 legal;
    logic                 load;
    logic [POS_W-1:0]     load_pos;
    logic                 force_idle;
    seq_state_t           cur_st;
    logic [BIT_W-1:0]     bit_cnt;

    logic [LINKS-1:0]     wr_v;
    logic [TS_W-1:0]      wr_ts   [LINKS];
    logic [BYTE_W-1:0]    wr_data [LINKS];
    logic [SIG_W-1:0]     wr_sig  [LINKS];

    logic [LINKS-1:0]     hv;
    logic [TS_W-1:0]      hts     [LINKS];
    logic [BYTE_W-1:0]    hd      [LINKS];
    logic [SIG_W-1:0]     hs      [LINKS];
    logic [LINKS-1:0]     rd_v;
    logic [LINKS-1:0]     hit;

    logic [BYTE_W-1:0]    src_d, src_s;
    logic [TS_W-1:0]      slot;
    logic [1:0]           lane;

    assign legal = (map_sel != MAP_RAW);

    always_ff @(posedge bp_clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !legal;
        end
    end

    assign wr_v       = {l1_wr, l0_wr};
    assign wr_ts[0]   = l0_ts;
    assign wr_ts[1]   = l1_ts;
    assign wr_data[0] = l0_data;
    assign wr_data[1] = l1_data;
    assign wr_sig[0]  = l0_sig;
    assign wr_sig[1]  = l1_sig;

    frame_seq #(
        .FRAME_POS (FRAME_POS),
        .BYTE_W    (BYTE_W)
    ) i_seq (
        .clk        (bp_clk),
        .rst_n      (rst_n),
        .fp         (fp),
        .legal      (legal),
        .load       (load),
        .load_pos   (load_pos),
        .force_idle (force_idle),
        .state      (cur_st),
        .bit_cnt    (bit_cnt)
    );

    assign slot = load_pos[POS_W-1:2];
    assign lane = load_pos[1:0];

    for (genvar i = 0; i < LINKS; i++) begin : g_link
        assign rd_v[i] = load && (lane == 2'(i));
        assign hit[i]  = rd_v[i] && hv[i] && (hts[i] == slot);

        link_hold #(
            .TS_W   (TS_W),
            .BYTE_W (BYTE_W),
            .SIG_W  (SIG_W)
        ) i_hold (
            .clk     (bp_clk),
            .rst_n   (rst_n),
            .clr     (!legal),
            .wr      (wr_v[i]),
            .wr_ts   (wr_ts[i]),
            .wr_data (wr_data[i]),
            .wr_sig  (wr_sig[i]),
            .rd      (rd_v[i]),
            .valid   (hv[i]),
            .ts      (hts[i]),
            .data    (hd[i]),
            .sig     (hs[i])
        );
    end

    always_comb begin
        src_d = '1;
        src_s = '1;
        for (int i = 0; i < LINKS; i++) begin
            if (hit[i]) begin
                src_d = hd[i];
                src_s = {{(BYTE_W - SIG_W){1'b1}}, hs[i]};
            end
        end
    end

    byte_shifter #(
        .BYTE_W (BYTE_W)
    ) i_shift (
        .clk        (bp_clk),
        .rst_n      (rst_n),
        .load       (load),
        .force_idle (force_idle),
        .d_in       (src_d),
        .s_in       (src_s),
        .sdata      (sdata),
        .ssig       (ssig)
    );

endmodule

// File: rtl/bp_byte_mux_chk.sv
module bp_byte_mux_chk
    import bp_mux_pkg::*;
#(
    parameter int BIT_W = 3
) (
    input logic             bp_clk,
    input logic             rst_n,
    input logic             fp,
    input logic [1:0]       map_sel,
    input logic             l0_wr,
    input logic             sdata,
    input logic             ssig,
    input logic             cfg_err,
    input seq_state_t       cur_st,
    input logic [BIT_W-1:0] bit_cnt,
    input logic [1:0]       rd_v,
    input logic [1:0]       hv
);

    // R1
    fp_start_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        (fp && map_sel != MAP_RAW) |=> (cur_st == ST_LINK0 && bit_cnt == '0));

    // R3
    fill_ones_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        (cur_st == ST_FILL) |-> (sdata && ssig));

    // R4
    sig_pad_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        ((cur_st == ST_LINK0 || cur_st == ST_LINK1) && bit_cnt < BIT_W'(4)) |-> ssig);

    // R6
    consume_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        (rd_v[0] && !l0_wr && map_sel != MAP_RAW) |=> !hv[0]);

    // R9
    cfg_flag_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        (map_sel == MAP_RAW) |=> cfg_err);

    // R9
    cfg_idle_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        cfg_err |-> (sdata && ssig && hv == 2'b00));

    // R10
    hunt_idle_chk: assert property (@(posedge bp_clk) disable iff (!rst_n)
        (cur_st == ST_HUNT) |-> (sdata && ssig));

endmodule

bind bp_byte_mux bp_byte_mux_chk #(
    .BIT_W (BIT_W)
) i_chk (
    .bp_clk  (bp_clk),
    .rst_n   (rst_n),
    .fp      (fp),
    .map_sel (map_sel),
    .l0_wr   (l0_wr),
    .sdata   (sdata),
    .ssig    (ssig),
    .cfg_err (cfg_err),
    .cur_st  (cur_st),
    .bit_cnt (bit_cnt),
    .rd_v    (rd_v),
    .hv      (hv)
);

// File: tb/test_bp_byte_mux.sv
module test_bp_byte_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic [1:0] map_sel = 2'b01;
    logic       l0_wr = 1'b0, l1_wr = 1'b0;
    logic [4:0] l0_ts = '0, l1_ts = '0;
    logic [7:0] l0_data = '0, l1_data = '0;
    logic [3:0] l0_sig = '0, l1_sig = '0;
    logic       sdata, ssig, cfg_err;

    always #2 clk = ~clk;

    bp_byte_mux i_bp_byte_mux (
        .bp_clk  (clk),
        .rst_n   (rst_n),
        .fp      (fp),
        .map_sel (map_sel),
        .l0_wr   (l0_wr),
        .l0_ts   (l0_ts),
        .l0_data (l0_data),
        .l0_sig  (l0_sig),
        .l1_wr   (l1_wr),
        .l1_ts   (l1_ts),
        .l1_data (l1_data),
        .l1_sig  (l1_sig),
        .sdata   (sdata),
        .ssig    (ssig),
        .cfg_err (cfg_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    bit         m_run, m_err;
    int         m_pos, m_bit;
    logic [7:0] m_d, m_s;
    string      m_tag;
    bit         m_hv [2];
    int         m_hts[2];
    logic [7:0] m_hd [2];
    logic [3:0] m_hs [2];

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d bit=%0d act=%b exp=%b", req, m_pos, m_bit, act, exp);
        end
    endtask

    task automatic load_byte(int p);
        int ln = p % 4;
        int k  = p / 4;
        if (ln >= 2) begin
            m_d = 8'hFF; m_s = 8'hFF; m_tag = "R3";
        end else begin
            if (m_hv[ln] && m_hts[ln] == k) begin
                m_d = m_hd[ln]; m_s = {4'hF, m_hs[ln]}; m_tag = "R5";
            end else begin
                m_d = 8'hFF; m_s = 8'hFF; m_tag = "R6";
            end
            m_hv[ln] = 0;
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_run = 0; m_err = 0; m_pos = 0; m_bit = 0;
            m_d = 8'hFF; m_s = 8'hFF; m_tag = "R11";
            m_hv[0] = 0; m_hv[1] = 0;
        end else if (map_sel == 2'b00) begin
            m_err = 1; m_run = 0; m_d = 8'hFF; m_s = 8'hFF; m_tag = "R9";
            m_hv[0] = 0; m_hv[1] = 0;
        end else begin
            m_err = 0;
            if (fp) begin
                bit mid = m_run && !(m_pos == 127 && m_bit == 7);
                m_run = 1; m_pos = 0; m_bit = 0;
                load_byte(0);
                m_tag = mid ? "R8" : "R1";
            end else if (m_run) begin
                if (m_bit == 7) begin
                    m_pos = (m_pos + 1) % 128; m_bit = 0;
                    load_byte(m_pos);
                    if (m_pos == 0) m_tag = "R7";
                    else if (m_pos % 4 < 2 && m_tag == "R5") m_tag = "R2";
                end else begin
                    m_bit++;
                end
            end else begin
                m_tag = "R10";
            end
            if (l0_wr) begin
                m_hv[0] = 1; m_hts[0] = int'(l0_ts); m_hd[0] = l0_data; m_hs[0] = l0_sig;
            end
            if (l1_wr) begin
                m_hv[1] = 1; m_hts[1] = int'(l1_ts); m_hd[1] = l1_data; m_hs[1] = l1_sig;
            end
        end
    endtask

    task automatic compare();
        logic ed, es;
        string stag;
        ed = m_run ? m_d[7 - m_bit] : 1'b1;
        es = m_run ? m_s[7 - m_bit] : 1'b1;
        stag = (m_run && (m_pos % 4) < 2) ? "R4" : m_tag;
        check(m_tag, sdata, ed);
        check(stag, ssig, es);
        check(rst_n ? "R9" : "R11", cfg_err, m_err);
    endtask

    initial begin
        int ph = 1000;
        int fr = -1;
        repeat (3) begin
            @(posedge clk); model_edge();
            @(negedge clk); compare();
        end
        rst_n = 1'b1;
        while (fr < 6) begin
            if (ph == 1024) begin
                ph = 0; fr++;
            end
            fp = (ph == 0 && fr >= 0 && fr != 2);
            if (fr == 3 && ph == 400) begin
                ph = 0; fr = 4; fp = 1'b1;
            end
            map_sel = (fr == 4 && ph >= 600 && ph < 640) ? 2'b00 : 2'(1 + ((fr + 3) % 3));
            l0_wr = 1'b0; l1_wr = 1'b0;
            if ((ph + 12) % 32 == 0) begin
                int k = ((ph + 12) / 32) % 32;
                l0_wr = 1'b1;
                l0_ts = 5'((fr == 1 && k == 7) ? k + 1 : k);
                l0_data = 8'((k * 7 + fr * 31) & 255);
                l0_sig = 4'((k + fr) & 15);
            end
            if ((ph + 4) % 32 == 0) begin
                int k = ((ph + 4) / 32) % 32;
                l1_wr = !(fr == 1 && k == 9);
                l1_ts = 5'(k);
                l1_data = 8'((k * 5 + fr * 13 + 100) & 255);
                l1_sig = 4'((k + fr + 1) & 15);
            end
            @(posedge clk); model_edge();
            ph++;
            @(negedge clk); compare();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule